// File: doc/BRIEF.md
# I2C Master Receive Byte Engine

This block is the receive half of a host-controlled I2C master once the bus has been turned around into master-receiver operation. It drives the open-drain SCL and SDA pull-down enables, samples SDA, and shifts the received bits into a byte register, most significant bit first. Between words it keeps SCL low and waits for the host. Each host read of the data register releases SCL and starts the next transfer. The transfer length and whether an acknowledge clock follows come from two host fields that are captured at that read.

A reception ends in three steps. First the host clears acknowledge-enable before the read that starts the final word, so that word gets no acknowledge pulse. Next the host sets the bit count to one and reads again, and the engine clocks one bit with SDA released, which the slave takes as a not-acknowledge. Last, a stop request makes the engine form a stop condition. The value in the data register before the first real word is not meaningful.

States and transitions. HOLD holds SCL low and waits. A read in HOLD moves to DLOW. Otherwise a stop request in HOLD moves to SLOW. DLOW is the SCL-low half of a data bit and moves to DHIGH. DHIGH is the SCL-high half: SDA is sampled on its last cycle. It moves to DLOW while bits remain, otherwise to ALOW if acknowledge was enabled, otherwise to SETTLE. ALOW and then AHIGH form the acknowledge clock and move on to SETTLE. SETTLE lasts one cycle with SCL low and moves to HOLD while raising the interrupt. SLOW (SDA low, SCL low) moves to SHIGH (SCL released). SHIGH moves to DONE, which releases SDA and stays there.

Top module: `i2c_rx_engine`

## Requirements
- R1: After reset the pull-down enable for SCL is 1 and the one for SDA is 0. The pending flag, the interrupt, stop_done and rx_byte are all 0.
- R2: A read strobe in HOLD is accepted on that clock edge. The pending flag is 1 from the next cycle. SCL stays pulled low for HALF_CYC more cycles and is then released.
- R3: Each SCL low phase and each SCL high phase lasts HALF_CYC cycles. SDA is sampled on the last cycle of each high phase. rx_byte shifts left by one and the new bit enters bit 0, so the first bit received ends up as the most significant one.
- R4: The bit-count code 0 gives 8 data bits. A code from 1 to 7 gives that many bits. The code is captured at the accepted read.
- R5: If acknowledge-enable was 1 at the accepted read, one extra SCL low/high pulse follows the data bits. The SDA enable is 1 from the second cycle of that low phase until the end of the SETTLE cycle.
- R6: If acknowledge-enable was 0, no extra pulse follows the data bits, and the SDA enable stays 0 for the whole transfer. This case, with a bit count of 1, is the not-acknowledge step.
- R7: When a word ends (one cycle in SETTLE with SCL low), the interrupt is 1 for exactly the first HOLD cycle. The pending flag drops to 0 on that cycle. SCL stays pulled low until the next accepted read.
- R8: A read strobe or a stop request that arrives outside HOLD has no effect on the running transfer or its result.
- R9: A stop request in HOLD pulls SDA low for HALF_CYC cycles with SCL low, then releases SCL for HALF_CYC cycles, then releases SDA and sets stop_done. stop_done stays 1 and both lines stay released; later reads are ignored.
- R10: A read strobe and a stop request in the same HOLD cycle start a transfer; the stop request is dropped.
- R11: The SDA enable changes only in a cycle that follows a cycle with SCL pulled low. The one exception is the SDA release that completes a stop, which coincides with stop_done rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_bits | input | BC_W | Bit-count code for the next transfer (0 means DATA_W) |
| ack_en | input | 1 | Acknowledge clock enable for the next transfer |
| rd_strobe | input | 1 | One-cycle host read of the data register |
| stop_req | input | 1 | Request for a stop condition |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| rx_byte | output | DATA_W | Received data shift register |
| xfer_pend | output | 1 | 1 while a started transfer is in progress |
| word_irq | output | 1 | One-cycle pulse at the end of each transfer |
| stop_done | output | 1 | Sticky flag set when the stop condition is complete |

## Verification
The two functions that can fall in the same cycle are the read that starts a transfer and the stop request. Both are accepted only in HOLD, so the bench raises both strobes on one HOLD cycle and also sends a stop request in the middle of a running word. It judges the result against its behavioural model. The model predicts a full transfer with its shifted byte, stop_done staying 0 and SCL held low afterwards. A real stop later confirms that the stop path still works.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
    typedef enum logic [3:0] {
        ST_HOLD,
        ST_DLOW,
        ST_DHIGH,
        ST_ALOW,
        ST_AHIGH,
        ST_SETTLE,
        ST_SLOW,
        ST_SHIGH,
        ST_DONE
    } rx_state_t;
endpackage

// File: rtl/i2crx_phase_timer.sv
module i2crx_phase_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_first,
    output logic phase_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign phase_end   = run && (cnt == LAST);
    assign phase_first = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || phase_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2crx_shifter.sv
module i2crx_shifter #(
    parameter int DATA_W = 8,
    parameter int BC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BC_W-1:0]   bc_code,
    input  logic              sample,
    input  logic              sda_bit,
    output logic [DATA_W-1:0] data,
    output logic              last_bit
);
    localparam int LW = $clog2(DATA_W + 1);

    logic [LW-1:0] bits_left;
    logic [LW-1:0] load_val;

    always_comb begin
        if (bc_code == '0) begin
            load_val = LW'(DATA_W);
        end else begin
            load_val = LW'(bc_code);
        end
    end

    assign last_bit = (bits_left == LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left <= '0;
            data      <= '0;
        end else if (load) begin
            bits_left <= load_val;
        end else if (sample) begin
            bits_left <= bits_left - 1'b1;
            data      <= {data[DATA_W-2:0], sda_bit};
        end
    end
endmodule

// File: rtl/i2crx_fsm.sv
module i2crx_fsm
    import i2crx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic stop_req,
    input  logic ack_en,
    input  logic phase_first,
    input  logic phase_end,
    input  logic last_bit,
    output logic load,
    output logic sample,
    output logic timer_run,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic xfer_pend,
    output logic word_irq,
    output logic stop_done
);
    rx_state_t state, nxt;
    logic      ack_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (rd_strobe) begin
                    nxt = ST_DLOW;
                end else if (stop_req) begin
                    nxt = ST_SLOW;
                end
            end
            ST_DLOW:   if (phase_end) nxt = ST_DHIGH;
            ST_DHIGH: begin
                if (phase_end) begin
                    if (!last_bit)  nxt = ST_DLOW;
                    else if (ack_q) nxt = ST_ALOW;
                    else            nxt = ST_SETTLE;
                end
            end
            ST_ALOW:   if (phase_end) nxt = ST_AHIGH;
            ST_AHIGH:  if (phase_end) nxt = ST_SETTLE;
            ST_SETTLE: nxt = ST_HOLD;
            ST_SLOW:   if (phase_end) nxt = ST_SHIGH;
            ST_SHIGH:  if (phase_end) nxt = ST_DONE;
            ST_DONE:   nxt = ST_DONE;
            default:   nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        load          = (state == ST_HOLD) && rd_strobe;
        sample        = (state == ST_DHIGH) && phase_end;
        timer_run     = 1'b0;
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (state)
            ST_HOLD:   scl_drive_low = 1'b1;
            ST_DLOW: begin
                timer_run     = 1'b1;
                scl_drive_low = 1'b1;
            end
            ST_DHIGH:  timer_run = 1'b1;
            ST_ALOW: begin
                timer_run     = 1'b1;
                scl_drive_low = 1'b1;
                sda_drive_low = !phase_first;
            end
            ST_AHIGH: begin
                timer_run     = 1'b1;
                sda_drive_low = 1'b1;
            end
            ST_SETTLE: begin
                scl_drive_low = 1'b1;
                sda_drive_low = ack_q;
            end
            ST_SLOW: begin
                timer_run     = 1'b1;
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            ST_SHIGH: begin
                timer_run     = 1'b1;
                sda_drive_low = 1'b1;
            end
            ST_DONE: ;
            default: scl_drive_low = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            xfer_pend <= 1'b0;
            word_irq  <= 1'b0;
            stop_done <= 1'b0;
        end else begin
            word_irq <= (state == ST_SETTLE);
            if (load) begin
                ack_q     <= ack_en;
                xfer_pend <= 1'b1;
            end else if (state == ST_SETTLE) begin
                xfer_pend <= 1'b0;
            end
            if ((state == ST_SHIGH) && phase_end) begin
                stop_done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine #(
    parameter int HALF_CYC = 4,
    parameter int DATA_W   = 8,
    parameter int BC_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BC_W-1:0]   word_bits,
    input  logic              ack_en,
    input  logic              rd_strobe,
    input  logic              stop_req,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [DATA_W-1:0] rx_byte,
    output logic              xfer_pend,
    output logic              word_irq,
    output logic              stop_done
);
    logic load, sample, timer_run;
    logic phase_first, phase_end, last_bit;

    i2crx_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (timer_run),
        .phase_first (phase_first),
        .phase_end   (phase_end)
    );

    i2crx_shifter #(.DATA_W(DATA_W), .BC_W(BC_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .bc_code  (word_bits),
        .sample   (sample),
        .sda_bit  (sda_in),
        .data     (rx_byte),
        .last_bit (last_bit)
    );

    i2crx_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_strobe     (rd_strobe),
        .stop_req      (stop_req),
        .ack_en        (ack_en),
        .phase_first   (phase_first),
        .phase_end     (phase_end),
        .last_bit      (last_bit),
        .load          (load),
        .sample        (sample),
        .timer_run     (timer_run),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .xfer_pend     (xfer_pend),
        .word_irq      (word_irq),
        .stop_done     (stop_done)
    );
endmodule

// File: rtl/i2crx_checker.sv
module i2crx_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_strobe,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic xfer_pend,
    input logic word_irq,
    input logic stop_done
);
    // R2
    pend_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_pend) |-> $past(rd_strobe));

    // R7
    irq_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_irq |-> (!xfer_pend && scl_drive_low));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_irq |=> !word_irq);

    // R8
    read_mid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pend && rd_strobe) |=> (xfer_pend || word_irq));

    // R9
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |=> stop_done);

    // R9
    stop_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> (!scl_drive_low && !sda_drive_low));

    // R11
    sda_when_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> ($past(scl_drive_low) || stop_done));
endmodule

bind i2c_rx_engine i2crx_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_strobe     (rd_strobe),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .xfer_pend     (xfer_pend),
    .word_irq      (word_irq),
    .stop_done     (stop_done)
);

// File: tb/i2c_rx_engine_test.sv
module i2c_rx_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] word_bits = 3'd0;
    logic       ack_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       stop_req = 1'b0;
    logic       sda_in;
    logic       scl_drive_low, sda_drive_low, xfer_pend, word_irq, stop_done;
    logic [7:0] rx_byte;

    logic [7:0] slave_byte = 8'hFF;
    logic       slave_bit = 1'b1;

    int  n_checks = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  finished = 0;

    // behavioural model: 0 hold, 1 transfer, 2 stop, 3 done
    int         m_mode = 0;
    int         m_k = 0;
    int         m_n = 8;
    bit         m_ack = 0;
    bit         m_pend = 0;
    bit         m_irq = 0;
    bit         m_done = 0;
    logic [7:0] m_data = 8'h00;
    logic       prev_scl = 1'b1;
    logic       prev_sda = 1'b0;

    assign sda_in = !sda_drive_low && slave_bit;

    i2c_rx_engine #(.HALF_CYC(H), .DATA_W(8), .BC_W(3)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_bits     (word_bits),
        .ack_en        (ack_en),
        .rd_strobe     (rd_strobe),
        .stop_req      (stop_req),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .rx_byte       (rx_byte),
        .xfer_pend     (xfer_pend),
        .word_irq      (word_irq),
        .stop_done     (stop_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int xfer_len();
        return 2*H*m_n + (m_ack ? 2*H : 0) + 1;
    endfunction

    // model advances on the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_k = 0; m_pend = 0; m_irq = 0; m_done = 0; m_data = 8'h00;
        end else begin
            m_irq = 0;
            case (m_mode)
                0: begin
                    if (rd_strobe) begin
                        m_mode = 1; m_k = 0;
                        m_n = (word_bits == 3'd0) ? 8 : int'(word_bits);
                        m_ack = ack_en; m_pend = 1;
                    end else if (stop_req) begin
                        m_mode = 2; m_k = 0;
                    end
                end
                1: begin
                    if (m_k < 2*H*m_n && (m_k % (2*H)) == 2*H-1)
                        m_data = {m_data[6:0], slave_byte[7 - m_k/(2*H)]};
                    m_k++;
                    if (m_k == xfer_len()) begin
                        m_mode = 0; m_irq = 1; m_pend = 0;
                    end
                end
                2: begin
                    m_k++;
                    if (m_k == 2*H) begin
                        m_mode = 3; m_done = 1;
                    end
                end
                default: ;
            endcase
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        logic  e_scl, e_sda;
        string tag;
        if (rst_n && !finished) begin
            e_scl = 1'b1; e_sda = 1'b0; tag = "R7";
            case (m_mode)
                0: begin e_scl = 1'b1; e_sda = 1'b0; tag = "R7"; end
                1: begin
                    if (m_k < 2*H*m_n) begin
                        e_scl = (m_k % (2*H)) < H; e_sda = 1'b0;
                        tag = m_ack ? "R3" : "R6";
                    end else if (m_ack && m_k < 2*H*m_n + 2*H) begin
                        e_scl = (m_k - 2*H*m_n) < H;
                        e_sda = (m_k - 2*H*m_n) >= 1;
                        tag = "R5";
                    end else begin
                        e_scl = 1'b1; e_sda = m_ack; tag = m_ack ? "R5" : "R6";
                    end
                end
                2: begin e_scl = m_k < H; e_sda = 1'b1; tag = "R9"; end
                default: begin e_scl = 1'b0; e_sda = 1'b0; tag = "R9"; end
            endcase
            chk({tag, " lines"}, {scl_drive_low, sda_drive_low}, {e_scl, e_sda});
            chk("R2 R7 flags", {xfer_pend, word_irq, stop_done}, {m_pend, m_irq, m_done});
            if (m_mode == 0) chk("R4 rx_byte", rx_byte, m_data);
            if (sda_drive_low !== prev_sda && !stop_done)
                chk("R11 sda moved with scl high", prev_scl, 1'b1);
            prev_scl = scl_drive_low;
            prev_sda = sda_drive_low;
            if (m_mode == 1 && m_k < 2*H*m_n) slave_bit = slave_byte[7 - m_k/(2*H)];
            else                               slave_bit = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic start_word(input logic [2:0] bc, input logic ack, input logic with_stop);
        @(negedge clk);
        word_bits = bc; ack_en = ack; rd_strobe = 1'b1; stop_req = with_stop;
        @(negedge clk);
        rd_strobe = 1'b0; stop_req = 1'b0;
    endtask

    task automatic wait_hold();
        while (m_mode != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 scl", scl_drive_low, 1'b1);
        chk("R1 sda", sda_drive_low, 1'b0);
        chk("R1 flags", {xfer_pend, word_irq, stop_done}, 3'b000);
        chk("R1 rx_byte", rx_byte, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // word with acknowledge
        slave_byte = 8'hA5;
        start_word(3'd0, 1'b1, 1'b0);
        chk("R2 pend after read", xfer_pend, 1'b1);
        chk("R2 scl still low", scl_drive_low, 1'b1);
        wait_hold();
        chk("R3 R4 R5 byte A5", rx_byte, 8'hA5);

        // reads and stop requests mid-word are ignored
        slave_byte = 8'h3C;
        start_word(3'd0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        rd_strobe = 1'b1; word_bits = 3'd2;
        @(negedge clk);
        rd_strobe = 1'b0; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_hold();
        chk("R8 byte 3C", rx_byte, 8'h3C);
        chk("R8 no stop", stop_done, 1'b0);

        // short word of 3 bits
        slave_byte = 8'hA0;
        start_word(3'd3, 1'b1, 1'b0);
        wait_hold();
        chk("R4 three bits", rx_byte, 8'hE5);

        // final word without acknowledge
        slave_byte = 8'h96;
        start_word(3'd0, 1'b0, 1'b0);
        wait_hold();
        chk("R6 last word", rx_byte, 8'h96);

        // single not-acknowledge bit
        slave_byte = 8'hFF;
        start_word(3'd1, 1'b0, 1'b0);
        repeat (H) @(negedge clk);
        chk("R6 nack sda released", sda_drive_low, 1'b0);
        wait_hold();
        chk("R6 nack bit", rx_byte, 8'h2D);

        // read and stop in the same cycle
        slave_byte = 8'h40;
        start_word(3'd2, 1'b0, 1'b1);
        chk("R10 read won", xfer_pend, 1'b1);
        wait_hold();
        chk("R10 byte", rx_byte, 8'hB5);
        chk("R10 stop dropped", stop_done, 1'b0);
        chk("R10 scl held", scl_drive_low, 1'b1);

        // stop condition
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk("R9 sda low", {scl_drive_low, sda_drive_low}, 2'b11);
        repeat (2*H + 1) @(negedge clk);
        chk("R9 stop_done", stop_done, 1'b1);
        start_word(3'd0, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 read ignored", {scl_drive_low, sda_drive_low, xfer_pend}, 3'b000);
        chk("R9 byte kept", rx_byte, 8'hB5);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule